// File: doc/BRIEF.md
# Command-Filled Four-Entry Read Buffer

This block holds four independent entries of prefetched memory words. Software fills and empties them with commands instead of the buffer filling itself on a miss. A command carries a 3-bit operation, a 4-bit selector and a 32-bit operand. The operations invalidate every entry, invalidate one entry, or load 1, 4 or 8 consecutive words into a chosen entry from an address in the operand. Two more operations switch user-mode command access off and on.

Words are fetched one at a time over a request/acknowledge memory read port. A load unit can query the buffer through a lookup port. The answer, hit or miss plus the buffered word, comes back one cycle after the query. Addresses are used exactly as supplied.

Top module: `rbuf_top`

## Requirements
- R1: After reset every entry is invalid, user-mode access is off, `cmd_ready` is 1 and `mem_req` is 0.
- R2: Operation 000 with selector 0000 invalidates all four entries. The operand is ignored.
- R3: Operation 001 with selector 00ee invalidates only entry ee. The other entries keep their contents.
- R4: Operation 010 with selector LLee loads entry ee from the operand address. LL=00 loads 1 word aligned down to 4 bytes. LL=01 loads 4 words aligned down to 16 bytes. LL=10 loads 8 words aligned down to 32 bytes.
- R5: A load issues one request per word in ascending address order, 4 bytes apart. `mem_req` and `mem_addr` are held until `mem_ack` is seen high at a clock edge.
- R6: While a load runs, `cmd_ready` is 0 unless the presented operation is 000 or 001. The target entry turns valid only at the edge that accepts its last word.
- R7: A flush that covers the entry being loaded ends the load when the outstanding acknowledge arrives. That entry stays invalid.
- R8: Any other operation/selector pair is undefined. The cycle after it is accepted, `cmd_undef` pulses for one cycle and no state changes. Undefined pairs include 000 with a nonzero selector, 001 with selector bits [3:2] nonzero, 010 with LL=11, 100 or 101 with a nonzero selector, and operations 011, 110 and 111.
- R9: Operation 100 with selector 0000 turns user access off, and 101 with selector 0000 turns it on. An accepted command with `cmd_user`=1 while access is off does nothing, and `cmd_fault` pulses the next cycle.
- R10: A lookup hits when a valid entry's base word address plus its word count covers the requested word address. When several entries cover the address, the lowest-numbered one is used. `lk_rvalid`, `lk_hit` and `lk_data` appear one cycle after `lk_req`, and `lk_data` is 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_sub | input | 4 | Selector field |
| cmd_data | input | ADDR_W | Operand (load start address) |
| cmd_user | input | 1 | Command issued from user mode |
| cmd_undef | output | 1 | Undefined command pulse |
| cmd_fault | output | 1 | Privilege fault pulse |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | ADDR_W | Byte address of requested word |
| mem_ack | input | 1 | Memory returns the word this cycle |
| mem_rdata | input | DATA_W | Returned word |
| lk_req | input | 1 | Lookup query |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_rvalid | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | Lookup hit |
| lk_data | output | DATA_W | Buffered word on a hit, else 0 |

## Verification
The hardest situation to reach is a flush that lands on the entry still being filled. The flush must arrive while acknowledges trickle in at irregular times, and sometimes on the same edge as one. The stimulus starts 8-word loads while a pseudo-random acknowledge pattern runs, then issues a flush a few cycles later. This relies on flushes being accepted even when `cmd_ready` is low for loads. A second case flushes a different entry in mid-load and shows that the load still completes. Overlapping entries are built with different memory contents so that the lowest-index winner can be seen at the lookup port.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

   typedef enum logic [2:0] {
      OP_INV_ALL  = 3'b000,
      OP_INV_ONE  = 3'b001,
      OP_LOAD     = 3'b010,
      OP_USER_OFF = 3'b100,
      OP_USER_ON  = 3'b101
   } rb_op_e;

   typedef enum logic [2:0] {
      K_NONE, K_INV_ALL, K_INV_ONE, K_LOAD, K_USER_OFF, K_USER_ON
   } rb_kind_e;

   typedef struct packed {
      rb_kind_e   kind;
      logic       undef;
      logic [1:0] ent;
      logic [1:0] len_code;
   } rb_cmd_t;

   // word count for a load length code (R4)
   function automatic logic [3:0] len_words(input logic [1:0] code);
      case (code)
         2'b00:   return 4'd1;
         2'b01:   return 4'd4;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/rbuf_cmd_dec.sv
module rbuf_cmd_dec
   import rbuf_pkg::*;
(
   input  logic [2:0] op,
   input  logic [3:0] sub,
   output rb_cmd_t    cmd,
   output logic       is_flush
);

   // R8: anything not listed below stays undefined
   always_comb begin
      cmd = '{kind: K_NONE, undef: 1'b1, ent: sub[1:0], len_code: sub[3:2]};
      case (op)
         OP_INV_ALL:
            if (sub == 4'b0000) begin cmd.kind = K_INV_ALL; cmd.undef = 1'b0; end
         OP_INV_ONE:
            if (sub[3:2] == 2'b00) begin cmd.kind = K_INV_ONE; cmd.undef = 1'b0; end
         OP_LOAD:
            if (sub[3:2] != 2'b11) begin cmd.kind = K_LOAD; cmd.undef = 1'b0; end
         OP_USER_OFF:
            if (sub == 4'b0000) begin cmd.kind = K_USER_OFF; cmd.undef = 1'b0; end
         OP_USER_ON:
            if (sub == 4'b0000) begin cmd.kind = K_USER_ON; cmd.undef = 1'b0; end
         default: ;
      endcase
   end

   // R6: flush-class opcodes bypass the busy hold-off
   assign is_flush = (op == OP_INV_ALL) || (op == OP_INV_ONE);

endmodule

// File: rtl/rbuf_fill.sv
module rbuf_fill #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int N_ENT     = 4,
   parameter int MAX_WORDS = 8,
   localparam int EW       = $clog2(N_ENT),
   localparam int IW       = $clog2(MAX_WORDS),
   localparam int CW       = IW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [EW-1:0]     start_ent,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CW-1:0]     start_words,
   input  logic [N_ENT-1:0]  flush_mask,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              wr_en,
   output logic [EW-1:0]     wr_ent,
   output logic [IW-1:0]     wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              fill_done
);

   localparam int STEP = DATA_W / 8;

   logic              busy_q, abort_q;
   logic [EW-1:0]     ent_q;
   logic [ADDR_W-1:0] addr_q;
   logic [IW-1:0]     idx_q, last_q;
   logic              kill, step, at_last;

   // R7: a flush of the target, now or earlier, kills the fill
   assign kill    = abort_q | flush_mask[ent_q];
   assign step    = busy_q & mem_ack;
   assign at_last = (idx_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         abort_q <= 1'b0;
         ent_q   <= '0;
         addr_q  <= '0;
         idx_q   <= '0;
         last_q  <= '0;
      end else if (start) begin
         busy_q  <= 1'b1;
         abort_q <= 1'b0;
         ent_q   <= start_ent;
         addr_q  <= start_addr;
         idx_q   <= '0;
         last_q  <= IW'(start_words - CW'(1));
      end else if (step) begin
         if (kill || at_last) begin
            busy_q  <= 1'b0;
            abort_q <= 1'b0;
         end else begin
            idx_q  <= idx_q + IW'(1);
            addr_q <= addr_q + ADDR_W'(STEP);   // R5 ascending
         end
      end else if (busy_q && flush_mask[ent_q]) begin
         abort_q <= 1'b1;
      end
   end

   assign busy      = busy_q;
   assign mem_req   = busy_q;
   assign mem_addr  = addr_q;
   assign wr_en     = step & ~kill;
   assign wr_ent    = ent_q;
   assign wr_idx    = idx_q;
   assign wr_data   = mem_rdata;
   assign fill_done = step & ~kill & at_last;   // R6

endmodule

// File: rtl/rbuf_store.sv
module rbuf_store #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int N_ENT     = 4,
   parameter int MAX_WORDS = 8,
   localparam int EW       = $clog2(N_ENT),
   localparam int IW       = $clog2(MAX_WORDS),
   localparam int CW       = IW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_ENT-1:0]  clr_mask,
   input  logic              load_set,
   input  logic [EW-1:0]     set_ent,
   input  logic [ADDR_W-1:0] set_base,
   input  logic [CW-1:0]     set_cnt,
   input  logic              wr_en,
   input  logic [EW-1:0]     wr_ent,
   input  logic [IW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fill_done,
   input  logic              lk_req,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_rvalid,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data
);

   logic [N_ENT-1:0]             hit_vec;
   logic [N_ENT-1:0][DATA_W-1:0] ent_rd;
   logic                         sel_hit;
   logic [DATA_W-1:0]            sel_data;

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      logic              v_q;
      logic [ADDR_W-1:0] base_q;
      logic [CW-1:0]     cnt_q;
      logic [DATA_W-1:0] words_q [MAX_WORDS];
      logic [ADDR_W-1:0] off;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
         end else begin
            if (clr_mask[g])
               v_q <= 1'b0;
            else if (fill_done && wr_ent == EW'(g))
               v_q <= 1'b1;
            if (load_set && set_ent == EW'(g)) begin
               base_q <= set_base;
               cnt_q  <= set_cnt;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && wr_ent == EW'(g))
            words_q[wr_idx] <= wr_data;
      end

      // R10: word distance from the entry base, compared to its count
      assign off        = (lk_addr >> 2) - (base_q >> 2);
      assign hit_vec[g] = v_q && (off < ADDR_W'(cnt_q));
      assign ent_rd[g]  = words_q[off[IW-1:0]];
   end

   // R10: lowest index wins
   always_comb begin
      sel_hit  = 1'b0;
      sel_data = '0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            sel_hit  = 1'b1;
            sel_data = ent_rd[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_rvalid <= 1'b0;
         lk_hit    <= 1'b0;
         lk_data   <= '0;
      end else begin
         lk_rvalid <= lk_req;
         lk_hit    <= lk_req & sel_hit;
         lk_data   <= (lk_req && sel_hit) ? sel_data : '0;
      end
   end

endmodule

// File: rtl/rbuf_top.sv
module rbuf_top
   import rbuf_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int N_ENT     = 4,
   parameter int MAX_WORDS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [3:0]        cmd_sub,
   input  logic [ADDR_W-1:0] cmd_data,
   input  logic              cmd_user,
   output logic              cmd_undef,
   output logic              cmd_fault,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              lk_req,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_rvalid,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data
);

   localparam int EW = $clog2(N_ENT);
   localparam int IW = $clog2(MAX_WORDS);
   localparam int CW = IW + 1;

   // the command encoding fixes these shapes
   if (N_ENT != 4) begin : g_bad_ent
      $error("rbuf_top: selector field addresses exactly four entries");
   end
   if (MAX_WORDS != 8) begin : g_bad_len
      $error("rbuf_top: longest load is eight words");
   end
   if (DATA_W != 32 || ADDR_W < 8) begin : g_bad_width
      $error("rbuf_top: 32-bit words and at least 8 address bits required");
   end

   rb_cmd_t           dcmd;
   logic              is_flush, busy;
   logic              user_en_q;
   logic              acc, deny, act, ld_go;
   logic [N_ENT-1:0]  flush_mask, clr_mask;
   logic [ADDR_W-1:0] ld_base;
   logic [CW-1:0]     ld_words;
   logic              wr_en, fill_done;
   logic [EW-1:0]     wr_ent;
   logic [IW-1:0]     wr_idx;
   logic [DATA_W-1:0] wr_data;

   rbuf_cmd_dec u_dec (
      .op       (cmd_op),
      .sub      (cmd_sub),
      .cmd      (dcmd),
      .is_flush (is_flush)
   );

   // R6: loads and mode changes wait; flushes are always taken
   assign cmd_ready = ~busy | is_flush;
   assign acc       = cmd_valid & cmd_ready;
   assign deny      = acc & cmd_user & ~user_en_q;          // R9
   assign act       = acc & ~deny & ~dcmd.undef;            // R8
   assign ld_go     = act && dcmd.kind == K_LOAD;

   always_comb begin
      flush_mask = '0;
      if (act && dcmd.kind == K_INV_ALL) flush_mask = '1;     // R2
      if (act && dcmd.kind == K_INV_ONE) flush_mask[dcmd.ent] = 1'b1;  // R3
   end

   always_comb begin
      clr_mask = flush_mask;
      if (ld_go) clr_mask[dcmd.ent] = 1'b1;
   end

   // R4: align the start down to the load length
   always_comb begin
      case (dcmd.len_code)
         2'b00:   ld_base = cmd_data & ~ADDR_W'(3);
         2'b01:   ld_base = cmd_data & ~ADDR_W'(15);
         default: ld_base = cmd_data & ~ADDR_W'(31);
      endcase
   end
   assign ld_words = CW'(len_words(dcmd.len_code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         user_en_q <= 1'b0;
         cmd_undef <= 1'b0;
         cmd_fault <= 1'b0;
      end else begin
         cmd_undef <= acc & ~deny & dcmd.undef;
         cmd_fault <= deny;
         if (act && dcmd.kind == K_USER_OFF) user_en_q <= 1'b0;
         if (act && dcmd.kind == K_USER_ON)  user_en_q <= 1'b1;
      end
   end

   rbuf_fill #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_ENT(N_ENT), .MAX_WORDS(MAX_WORDS)
   ) u_fill (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (ld_go),
      .start_ent   (dcmd.ent),
      .start_addr  (ld_base),
      .start_words (ld_words),
      .flush_mask  (flush_mask),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .busy        (busy),
      .mem_req     (mem_req),
      .mem_addr    (mem_addr),
      .wr_en       (wr_en),
      .wr_ent      (wr_ent),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .fill_done   (fill_done)
   );

   rbuf_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_ENT(N_ENT), .MAX_WORDS(MAX_WORDS)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_mask  (clr_mask),
      .load_set  (ld_go),
      .set_ent   (dcmd.ent),
      .set_base  (ld_base),
      .set_cnt   (ld_words),
      .wr_en     (wr_en),
      .wr_ent    (wr_ent),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .fill_done (fill_done),
      .lk_req    (lk_req),
      .lk_addr   (lk_addr),
      .lk_rvalid (lk_rvalid),
      .lk_hit    (lk_hit),
      .lk_data   (lk_data)
   );

endmodule

// File: rtl/rbuf_checker.sv
module rbuf_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [2:0]        cmd_op,
   input logic              cmd_user,
   input logic              cmd_undef,
   input logic              cmd_fault,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic              lk_req,
   input logic              lk_rvalid,
   input logic              lk_hit,
   input logic [DATA_W-1:0] lk_data
);

   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!mem_req && cmd_ready));

   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   a_r5_ascend: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(4)));

   a_r6_load_held_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && cmd_op == 3'b010) |-> !cmd_ready);

   a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_undef && cmd_fault));

   a_r9_fault_needs_user: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_fault |-> $past(cmd_valid && cmd_ready && cmd_user));

   a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_rvalid);

   a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_rvalid && !lk_hit) |-> lk_data == '0);

endmodule

bind rbuf_top rbuf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/rbuf_top_test.sv
module rbuf_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [3:0]  cmd_sub = '0;
   logic [31:0] cmd_data = '0;
   logic        cmd_user = 1'b0;
   logic        cmd_ready, cmd_undef, cmd_fault;
   logic        mem_req, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_rdata;
   logic        lk_req = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_rvalid, lk_hit;
   logic [31:0] lk_data;

   int errs = 0, checks = 0;
   logic [31:0] epoch = 32'hA000_0000;
   logic [15:0] lfsr = 16'hACE1;
   bit mon = 0, sweep = 1;
   int sw_i = 0;
   logic r_undef, r_fault;

   always #10 clk = ~clk;   // 50 MHz

   assign mem_rdata = mem_addr ^ epoch;

   rbuf_top uut (.*);

   // ---------------- reference model ----------------
   bit          m_valid [4];
   logic [31:0] m_base [4];
   int          m_cnt [4];
   logic [31:0] m_data [4][8];
   bit          m_busy = 0, m_abort = 0, m_uen = 0;
   int          m_tgt = 0, m_idx = 0, m_len = 0;
   logic [31:0] m_cur = '0;
   bit          e_rv = 0, e_hit = 0, e_undef = 0, e_fault = 0;
   logic [31:0] e_data = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) m_valid[i] = 0;
         m_busy = 0; m_abort = 0; m_uen = 0;
         e_rv = 0; e_hit = 0; e_data = '0; e_undef = 0; e_fault = 0;
      end else begin
         bit [3:0] fm;
         bit ld, uen_n;
         int ld_e, ld_n;
         logic [31:0] ld_a;
         fm = '0; ld = 0; uen_n = m_uen; ld_e = 0; ld_n = 0; ld_a = '0;
         // lookup (R10)
         e_rv = lk_req; e_hit = 0; e_data = '0;
         if (lk_req)
            for (int i = 3; i >= 0; i--) begin
               logic [31:0] off;
               off = (lk_addr >> 2) - (m_base[i] >> 2);
               if (m_valid[i] && off < 32'(m_cnt[i])) begin
                  e_hit = 1; e_data = m_data[i][off[2:0]];
               end
            end
         // command
         e_undef = 0; e_fault = 0;
         if (cmd_valid && (!m_busy || cmd_op <= 3'd1)) begin
            if (cmd_user && !m_uen) e_fault = 1;
            else case (cmd_op)
               3'd0: if (cmd_sub == 0) fm = 4'hF; else e_undef = 1;
               3'd1: if (cmd_sub[3:2] == 0) fm[cmd_sub[1:0]] = 1'b1; else e_undef = 1;
               3'd2: if (cmd_sub[3:2] != 2'b11) begin
                        ld = 1; ld_e = int'(cmd_sub[1:0]);
                        ld_n = (cmd_sub[3:2] == 0) ? 1 : (cmd_sub[3:2] == 1) ? 4 : 8;
                        ld_a = cmd_data & ~(32'(ld_n * 4) - 32'd1);
                     end else e_undef = 1;
               3'd4: if (cmd_sub == 0) uen_n = 0; else e_undef = 1;
               3'd5: if (cmd_sub == 0) uen_n = 1; else e_undef = 1;
               default: e_undef = 1;
            endcase
         end
         // fill engine
         if (m_busy && mem_ack) begin
            if (m_abort || fm[m_tgt]) begin m_busy = 0; m_abort = 0; end
            else begin
               m_data[m_tgt][m_idx] = m_cur ^ epoch;
               if (m_idx == m_len - 1) begin m_busy = 0; m_valid[m_tgt] = 1; end
               else begin m_idx++; m_cur += 4; end
            end
         end else if (m_busy && fm[m_tgt]) m_abort = 1;
         for (int i = 0; i < 4; i++) if (fm[i]) m_valid[i] = 0;
         if (ld) begin
            m_valid[ld_e] = 0; m_base[ld_e] = ld_a; m_cnt[ld_e] = ld_n;
            m_busy = 1; m_abort = 0; m_tgt = ld_e; m_cur = ld_a; m_idx = 0; m_len = ld_n;
         end
         m_uen = uen_n;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (mon) begin
      chk("R10 lk_rvalid", 32'(lk_rvalid), 32'(e_rv));
      chk("R10 lk_hit", 32'(lk_hit), 32'(e_hit));
      chk("R10 lk_data", lk_data, e_data);
      chk("R8 cmd_undef", 32'(cmd_undef), 32'(e_undef));
      chk("R9 cmd_fault", 32'(cmd_fault), 32'(e_fault));
      #5;
      chk("R6 cmd_ready", 32'(cmd_ready), 32'(!m_busy || cmd_op <= 3'd1));
      chk("R5 mem_req", 32'(mem_req), 32'(m_busy));
      if (m_busy) chk("R5 mem_addr", mem_addr, m_cur);
   end

   // memory acknowledge pattern and lookup sweep
   always @(negedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ack = m_busy && (lfsr[0] || lfsr[1]);
   end

   always @(negedge clk) begin
      #1;
      if (sweep) begin
         lk_req  = lfsr[2] | lfsr[5];
         lk_addr = 32'h0FF8 + 32'(4 * sw_i);
         sw_i    = (sw_i + 1) % 80;
      end
   end

   task automatic issue(input logic [2:0] op, input logic [3:0] sub,
                        input logic [31:0] d, input logic usr);
      @(negedge clk); #2;
      cmd_valid = 1; cmd_op = op; cmd_sub = sub; cmd_data = d; cmd_user = usr;
      #3;
      while (m_busy && op > 3'd1) begin @(negedge clk); #5; end
      @(posedge clk); @(negedge clk); #1;
      r_undef = cmd_undef; r_fault = cmd_fault;
      cmd_valid = 0; cmd_op = 3'd7;
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic probe(input logic [31:0] a, input logic eh, input logic [31:0] ed,
                        input string tag);
      sweep = 0;
      @(negedge clk); #2;
      lk_req = 1; lk_addr = a;
      @(posedge clk); @(negedge clk); #1;
      chk({tag, " probe hit"}, 32'(lk_hit), 32'(eh));
      if (eh) chk({tag, " probe data"}, lk_data, ed);
      lk_req = 0;
      sweep = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++; checks++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      #1 rst_n = 1;
      mon = 1;
      @(negedge clk); #6;
      chk("R1 cmd_ready", 32'(cmd_ready), 32'd1);
      chk("R1 mem_req", 32'(mem_req), 32'd0);
      probe(32'h1004, 0, 0, "R1");

      // user command with access off
      issue(3'd2, 4'b0000, 32'h1006, 1);
      chk("R9 fault on user load", 32'(r_fault), 32'd1);
      probe(32'h1004, 0, 0, "R9");

      // loads of each length
      issue(3'd2, 4'b0000, 32'h1006, 0);
      chk("R4 legal load no undef", 32'(r_undef), 32'd0);
      wait_idle();
      probe(32'h1004, 1, 32'h1004 ^ 32'hA000_0000, "R4 one word");
      probe(32'h1008, 0, 0, "R4 one word end");
      issue(3'd2, 4'b0101, 32'h1018, 0);
      wait_idle();
      probe(32'h1010, 1, 32'h1010 ^ 32'hA000_0000, "R4 four base");
      probe(32'h101C, 1, 32'h101C ^ 32'hA000_0000, "R4 four last");
      probe(32'h1020, 0, 0, "R4 four end");
      epoch = 32'hB000_0000;
      issue(3'd2, 4'b1010, 32'h103C, 0);
      wait_idle();
      probe(32'h103C, 1, 32'h103C ^ 32'hB000_0000, "R4 eight last");
      epoch = 32'hC000_0000;
      issue(3'd2, 4'b0111, 32'h1024, 0);
      wait_idle();
      probe(32'h1024, 1, 32'h1024 ^ 32'hB000_0000, "R10 lowest wins");

      // single flush
      issue(3'd1, 4'b0010, 32'hFFFF_FFFF, 0);
      probe(32'h1024, 1, 32'h1024 ^ 32'hC000_0000, "R3 next entry");
      probe(32'h1038, 0, 0, "R3 flushed");
      probe(32'h1010, 1, 32'h1010 ^ 32'hA000_0000, "R3 other kept");

      // undefined commands
      issue(3'd3, 4'b0000, 0, 0);
      chk("R8 op 011", 32'(r_undef), 32'd1);
      issue(3'd1, 4'b0101, 0, 0);
      chk("R8 flush bad sub", 32'(r_undef), 32'd1);
      probe(32'h1010, 1, 32'h1010 ^ 32'hA000_0000, "R8 entry kept");
      issue(3'd2, 4'b1100, 32'h1200, 0);
      chk("R8 load len 11", 32'(r_undef), 32'd1);
      chk("R8 no fill", 32'(mem_req), 32'd0);
      probe(32'h1004, 1, 32'h1004 ^ 32'hA000_0000, "R8 entry0 kept");
      issue(3'd4, 4'b0001, 0, 0);
      chk("R8 off bad sub", 32'(r_undef), 32'd1);
      issue(3'd0, 4'b0001, 0, 0);
      chk("R8 flush-all bad sub", 32'(r_undef), 32'd1);
      issue(3'd6, 4'b0000, 0, 0);
      chk("R8 op 110", 32'(r_undef), 32'd1);
      issue(3'd5, 4'b0010, 0, 0);
      chk("R8 on bad sub", 32'(r_undef), 32'd1);
      issue(3'd1, 4'b0000, 0, 1);
      chk("R9 still off", 32'(r_fault), 32'd1);
      probe(32'h1004, 1, 32'h1004 ^ 32'hA000_0000, "R9 flush denied");

      // abort by flush during a load
      epoch = 32'hD000_0000;
      issue(3'd2, 4'b1000, 32'h1080, 0);
      @(negedge clk); #2;
      cmd_valid = 1; cmd_op = 3'd2; cmd_sub = 4'b0001; cmd_data = 32'h1300;
      #3 chk("R6 load held off", 32'(cmd_ready), 32'd0);
      #1 cmd_valid = 0; cmd_op = 3'd7;
      issue(3'd1, 4'b0000, 0, 0);
      wait_idle();
      probe(32'h1080, 0, 0, "R7 aborted");
      probe(32'h109C, 0, 0, "R7 aborted end");

      // flush of another entry mid-load; valid only after last word
      issue(3'd2, 4'b1001, 32'h10A0, 0);
      probe(32'h10A0, 0, 0, "R6 not yet valid");
      issue(3'd1, 4'b0011, 0, 0);
      wait_idle();
      probe(32'h10BC, 1, 32'h10BC ^ 32'hD000_0000, "R6 completed");
      probe(32'h1024, 0, 0, "R3 flushed mid-load");

      // privilege gate
      issue(3'd5, 4'b0000, 0, 0);
      issue(3'd2, 4'b0010, 32'h1100, 1);
      chk("R9 user allowed", 32'(r_fault), 32'd0);
      wait_idle();
      probe(32'h1100, 1, 32'h1100 ^ 32'hD000_0000, "R9 user load");
      issue(3'd4, 4'b0000, 0, 1);
      issue(3'd0, 4'b0000, 0, 1);
      chk("R9 off again", 32'(r_fault), 32'd1);
      probe(32'h1100, 1, 32'h1100 ^ 32'hD000_0000, "R9 denied flush");

      // flush all
      issue(3'd0, 4'b0000, 32'h1234_5678, 0);
      probe(32'h1100, 0, 0, "R2 all gone");
      probe(32'h10A0, 0, 0, "R2 all gone b");
      probe(32'h1010, 0, 0, "R2 all gone c");

      repeat (40) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule